// File: doc/BRIEF.md
# Interrupt Status Block with Per-Bit Event Capture

This block holds two small status registers that collect hardware events for software. The six-bit main register gives each bit its own capture rule: a sticky level, a sticky rising edge, a sticky falling edge, a sticky change on either edge, a bit that simply follows its input, or a plain read-write bit loaded by hardware under an enable. A five-bit halt register holds sticky level events, plus one plain bit that tracks its input. Software loads either register as a whole through a write strobe and a shared data bus. Both registers are readable at all times on output ports.

The main register is reduced to one interrupt line, with a per-bit mask on the two lowest bits. The halt register is reduced to one halt line, with a per-bit halt mask on its two lowest bits. The interrupt line is also registered into a one-bit chain flag, so that a downstream register can take it as its next value.

The block has no state machine. Each bit is a capture cell whose rule is picked at elaboration time from a mode code: LEVEL, RISE, FALL, BOTH, FOLLOW or PLAIN. A capture cell has two behaviours, hold and update. It updates on a software write, on a hardware event (sticky modes), on every cycle (FOLLOW), or under a hardware enable (PLAIN). Otherwise it holds.

Top module: `irq_status_block`

## Requirements
- R1: While `rst_n` is low, `stat_q`, `halt_q` and `chain_q` are 0 at once (asynchronous), and `irq_out` and `halt_out` are 0.
- R2: `stat_q[0]` is set at a rising clock edge where `evt_in[0]` is 1. It then stays 1 after the input returns to 0, until software writes it.
- R3: `stat_q[3]` is set at the clock edge where `evt_in[3]` is first seen at 1 after having been 0 on the previous edge. A steady level or a falling input does not set it.
- R4: `stat_q[2]` is set at the clock edge where `evt_in[2]` is first seen at 0 after having been 1 on the previous edge. A rising input does not set it.
- R5: `stat_q[1]` is set by any change of `evt_in[1]` between two consecutive clock edges, whether rising or falling.
- R6: `stat_q[4]` takes `plain_next` at an edge where `plain_en` is 1 and holds otherwise. `evt_in[4]` has no effect on it. It never drives `irq_out`.
- R7: `stat_q[5]` equals the value `evt_in[5]` had at the previous clock edge. It is not sticky.
- R8: With `irq_mask[k]` at 1 (k = 0 or 1), `stat_q[k]` still records its event but is kept out of `irq_out`.
- R9: `irq_out` is 1 exactly when any of `stat_q[3]`, `stat_q[2]` or `stat_q[5]` is 1, or when `stat_q[k]` is 1 with `irq_mask[k]` at 0 for k = 0 or 1.
- R10: `halt_q` bits 0, 1, 2 and 4 are sticky level captures of `halt_evt_in`. `halt_q[3]` equals the value `halt_evt_in[3]` had at the previous clock edge.
- R11: `halt_out` is 1 exactly when `halt_q[2]` or `halt_q[4]` is 1, or when `halt_q[k]` is 1 with `halt_mask[k]` at 0 for k = 0 or 1. `halt_q[3]` never drives it.
- R12: A clock edge with `sw_stat_we` loads `stat_q` from `sw_wdata`. A clock edge with `sw_halt_we` loads `halt_q` from `sw_wdata[4:0]`. In both cases the write overrides any hardware event or load in that same cycle.
- R13: `chain_q` equals the value `irq_out` had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_stat_we | input | 1 | Software write strobe for the main register |
| sw_halt_we | input | 1 | Software write strobe for the halt register |
| sw_wdata | input | 6 | Software write data, low 5 bits used for halt |
| evt_in | input | 6 | Hardware event inputs of the main register |
| plain_en | input | 1 | Hardware load enable for main bit 4 |
| plain_next | input | 1 | Hardware load value for main bit 4 |
| irq_mask | input | 2 | Interrupt masks for main bits 0 and 1 |
| halt_evt_in | input | 5 | Hardware inputs of the halt register |
| halt_mask | input | 2 | Halt masks for halt bits 0 and 1 |
| stat_q | output | 6 | Main register contents |
| halt_q | output | 5 | Halt register contents |
| irq_out | output | 1 | Summary interrupt |
| halt_out | output | 1 | Summary halt |
| chain_q | output | 1 | Registered summary interrupt for chaining |

## Verification
Each edge-capturing bit is driven with a rising step, a held level and a falling step, and each is cleared in between. This separates the rising, falling and both-edge rules from one another and from a level rule. Single-cycle pulses on the level and follow bits show sticky and non-sticky capture apart. Toggling the enable and data of the plain bit shows a held value apart from a loaded one. Masks are applied while events are still arriving, to show that recording and reporting are separate. Software writes are made both alone and in the same cycle as a hardware event, to show which of the two wins.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        CAP_LEVEL  = 3'd0,
        CAP_RISE   = 3'd1,
        CAP_FALL   = 3'd2,
        CAP_BOTH   = 3'd3,
        CAP_FOLLOW = 3'd4,
        CAP_PLAIN  = 3'd5
    } cap_mode_e;

    localparam int MODE_W = 3;
    localparam int STAT_W = 6;
    localparam int HALT_W = 5;
    localparam int QUAL_W = 2;

    // Mode of each bit, bit 0 in the lowest field
    localparam logic [MODE_W*STAT_W-1:0] STAT_MODES =
        {CAP_FOLLOW, CAP_PLAIN, CAP_RISE, CAP_FALL, CAP_BOTH, CAP_LEVEL};
    localparam logic [MODE_W*HALT_W-1:0] HALT_MODES =
        {CAP_LEVEL, CAP_PLAIN, CAP_LEVEL, CAP_LEVEL, CAP_LEVEL};

endpackage

// File: rtl/irq_bit_cell.sv
module irq_bit_cell
    import irq_pkg::*;
#(
    parameter cap_mode_e MODE = CAP_LEVEL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_we,
    input  logic sw_d,
    input  logic hw_in,
    input  logic hw_we,
    input  logic hw_d,
    output logic q
);

    logic prev_q;
    logic nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= hw_in;
    end

    always_comb begin
        case (MODE)
            CAP_LEVEL:  nxt = q | hw_in;
            CAP_RISE:   nxt = q | (hw_in & ~prev_q);
            CAP_FALL:   nxt = q | (~hw_in & prev_q);
            CAP_BOTH:   nxt = q | (hw_in ^ prev_q);
            CAP_FOLLOW: nxt = hw_in;
            default:    nxt = hw_we ? hw_d : q;
        endcase
        if (sw_we) nxt = sw_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

    // Software write lands regardless of hardware activity
    p_sw_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_we) |-> q == $past(sw_d));

    generate
        if (MODE == CAP_LEVEL || MODE == CAP_RISE ||
            MODE == CAP_FALL  || MODE == CAP_BOTH) begin : g_sticky
            p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(q) && !$past(sw_we)) |-> q);
        end
        if (MODE == CAP_RISE) begin : g_rise
            p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(sw_we) && !$past(q) && !$past(hw_in)) |-> !q);
        end
        if (MODE == CAP_FALL) begin : g_fall
            p_fall_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(sw_we) && !$past(q) && $past(hw_in)) |-> !q);
        end
        if (MODE == CAP_BOTH) begin : g_both
            p_any_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(sw_we) && ($past(hw_in) != $past(prev_q))) |-> q);
        end
        if (MODE == CAP_FOLLOW) begin : g_follow
            p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(sw_we) |-> q == $past(hw_in));
        end
        if (MODE == CAP_PLAIN) begin : g_plain
            p_plain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(sw_we) && !$past(hw_we)) |-> $stable(q));
        end
    endgenerate

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_pkg::*;
#(
    parameter int                     WIDTH = 6,
    parameter logic [3*WIDTH-1:0]     MODES = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [WIDTH-1:0] sw_d,
    input  logic [WIDTH-1:0] hw_in,
    input  logic [WIDTH-1:0] hw_we,
    input  logic [WIDTH-1:0] hw_d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            irq_bit_cell #(
                .MODE(cap_mode_e'(MODES[MODE_W*i +: MODE_W]))
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .sw_we (sw_we),
                .sw_d  (sw_d[i]),
                .hw_in (hw_in[i]),
                .hw_we (hw_we[i]),
                .hw_d  (hw_d[i]),
                .q     (q[i])
            );
        end
    endgenerate

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_pkg::*;
#(
    parameter int                 WIDTH  = 6,
    parameter int                 NQUAL  = 2,
    parameter logic [3*WIDTH-1:0] MODES  = '0
) (
    input  logic [WIDTH-1:0] q,
    input  logic [NQUAL-1:0] qual_off,
    output logic             any
);

    logic [WIDTH-1:0] term;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_term
            if (cap_mode_e'(MODES[MODE_W*i +: MODE_W]) == CAP_PLAIN) begin : g_none
                assign term[i] = q[i] & 1'b0;
            end else if (i < NQUAL) begin : g_qual
                assign term[i] = q[i] & ~qual_off[i];
            end else begin : g_direct
                assign term[i] = q[i];
            end
        end
    endgenerate

    assign any = |term;

endmodule

// File: rtl/irq_status_block.sv
module irq_status_block
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_stat_we,
    input  logic              sw_halt_we,
    input  logic [STAT_W-1:0] sw_wdata,
    input  logic [STAT_W-1:0] evt_in,
    input  logic              plain_en,
    input  logic              plain_next,
    input  logic [QUAL_W-1:0] irq_mask,
    input  logic [HALT_W-1:0] halt_evt_in,
    input  logic [QUAL_W-1:0] halt_mask,
    output logic [STAT_W-1:0] stat_q,
    output logic [HALT_W-1:0] halt_q,
    output logic              irq_out,
    output logic              halt_out,
    output logic              chain_q
);

    localparam int PLAIN_STAT = 4;
    localparam int PLAIN_HALT = 3;

    logic [STAT_W-1:0] stat_hw_we, stat_hw_d;
    logic [HALT_W-1:0] halt_hw_we, halt_hw_d;

    always_comb begin
        stat_hw_we             = '0;
        stat_hw_d              = '0;
        stat_hw_we[PLAIN_STAT] = plain_en;
        stat_hw_d[PLAIN_STAT]  = plain_next;
        halt_hw_we             = '0;
        halt_hw_d              = '0;
        halt_hw_we[PLAIN_HALT] = 1'b1;
        halt_hw_d[PLAIN_HALT]  = halt_evt_in[PLAIN_HALT];
    end

    irq_status_reg #(.WIDTH(STAT_W), .MODES(STAT_MODES)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_we (sw_stat_we),
        .sw_d  (sw_wdata),
        .hw_in (evt_in),
        .hw_we (stat_hw_we),
        .hw_d  (stat_hw_d),
        .q     (stat_q)
    );

    irq_status_reg #(.WIDTH(HALT_W), .MODES(HALT_MODES)) u_halt (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_we (sw_halt_we),
        .sw_d  (sw_wdata[HALT_W-1:0]),
        .hw_in (halt_evt_in),
        .hw_we (halt_hw_we),
        .hw_d  (halt_hw_d),
        .q     (halt_q)
    );

    irq_summary #(.WIDTH(STAT_W), .NQUAL(QUAL_W), .MODES(STAT_MODES)) u_irq_sum (
        .q        (stat_q),
        .qual_off (irq_mask),
        .any      (irq_out)
    );

    irq_summary #(.WIDTH(HALT_W), .NQUAL(QUAL_W), .MODES(HALT_MODES)) u_halt_sum (
        .q        (halt_q),
        .qual_off (halt_mask),
        .any      (halt_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= irq_out;
    end

    p_chain_r13: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q == $past(irq_out));

    p_plain_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == 6'b010000) |-> !irq_out);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 2'b11 && stat_q[3:2] == 2'b00 && !stat_q[5]) |-> !irq_out);

    p_unmasked_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !irq_mask[0]) |-> irq_out);

    p_halt_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_mask == 2'b11 && !halt_q[2] && !halt_q[4]) |-> !halt_out);

endmodule

// File: tb/tb_irq_status_block.sv
`timescale 1ns/1ps
module tb_irq_status_block;

    logic       clk, rst_n;
    logic       sw_stat_we, sw_halt_we;
    logic [5:0] sw_wdata, evt_in;
    logic       plain_en, plain_next;
    logic [1:0] irq_mask, halt_mask;
    logic [4:0] halt_evt_in;
    logic [5:0] stat_q;
    logic [4:0] halt_q;
    logic       irq_out, halt_out, chain_q;

    irq_status_block dut (
        .clk(clk), .rst_n(rst_n), .sw_stat_we(sw_stat_we), .sw_halt_we(sw_halt_we),
        .sw_wdata(sw_wdata), .evt_in(evt_in), .plain_en(plain_en), .plain_next(plain_next),
        .irq_mask(irq_mask), .halt_evt_in(halt_evt_in), .halt_mask(halt_mask),
        .stat_q(stat_q), .halt_q(halt_q), .irq_out(irq_out), .halt_out(halt_out),
        .chain_q(chain_q)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    typedef struct {
        logic [5:0] s;
        logic [4:0] h;
        logic       irq;
        logic       hlt;
        logic       ch;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // Reference model state
    logic [5:0] m_s, m_prev;
    logic [4:0] m_h;
    logic       m_ch;

    // Driven values for the next step
    logic [5:0] d_ev, d_wd;
    logic [4:0] d_hev;
    logic [1:0] d_m, d_hm;
    logic       d_pen, d_pnx, d_ws, d_wh;

    function automatic logic f_irq(logic [5:0] s, logic [1:0] m);
        return (s[0] & ~m[0]) | (s[1] & ~m[1]) | s[2] | s[3] | s[5];
    endfunction

    function automatic logic f_halt(logic [4:0] h, logic [1:0] m);
        return (h[0] & ~m[0]) | (h[1] & ~m[1]) | h[2] | h[4];
    endfunction

    task automatic go(input string req);
        logic [5:0] ns;
        logic [4:0] nh;
        exp_t e;
        @(negedge clk);
        evt_in = d_ev; plain_en = d_pen; plain_next = d_pnx; irq_mask = d_m;
        halt_evt_in = d_hev; halt_mask = d_hm; sw_stat_we = d_ws; sw_halt_we = d_wh;
        sw_wdata = d_wd;
        ns[0] = m_s[0] | d_ev[0];
        ns[1] = m_s[1] | (d_ev[1] ^ m_prev[1]);
        ns[2] = m_s[2] | (~d_ev[2] & m_prev[2]);
        ns[3] = m_s[3] | (d_ev[3] & ~m_prev[3]);
        ns[4] = d_pen ? d_pnx : m_s[4];
        ns[5] = d_ev[5];
        if (d_ws) ns = d_wd;
        nh    = m_h | d_hev;
        nh[3] = d_hev[3];
        if (d_wh) nh = d_wd[4:0];
        m_ch   = f_irq(m_s, d_m);
        m_s    = ns;
        m_h    = nh;
        m_prev = d_ev;
        e.s = m_s; e.h = m_h; e.irq = f_irq(m_s, d_m); e.hlt = f_halt(m_h, d_hm);
        e.ch = m_ch; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (stat_q !== e.s || halt_q !== e.h || irq_out !== e.irq ||
                    halt_out !== e.hlt || chain_q !== e.ch) begin
                    errors++;
                    $display("FAIL %s: stat=%b halt=%b irq=%b halt_out=%b chain=%b expected stat=%b halt=%b irq=%b halt_out=%b chain=%b",
                             e.req, stat_q, halt_q, irq_out, halt_out, chain_q,
                             e.s, e.h, e.irq, e.hlt, e.ch);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic clear_all(input string req);
        d_ws = 1'b1; d_wh = 1'b1; d_wd = '0;
        go(req);
        d_ws = 1'b0; d_wh = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        sw_stat_we = 0; sw_halt_we = 0; sw_wdata = 0; evt_in = 0; plain_en = 0;
        plain_next = 0; irq_mask = 0; halt_evt_in = 0; halt_mask = 0;
        d_ev = 0; d_wd = 0; d_hev = 0; d_m = 0; d_hm = 0;
        d_pen = 0; d_pnx = 0; d_ws = 0; d_wh = 0;
        m_s = 0; m_prev = 0; m_h = 0; m_ch = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (stat_q !== 0 || halt_q !== 0 || irq_out !== 0 || halt_out !== 0 || chain_q !== 0) begin
            errors++;
            $display("FAIL R1: stat=%b halt=%b irq=%b halt_out=%b chain=%b expected all zero",
                     stat_q, halt_q, irq_out, halt_out, chain_q);
        end
        rst_n = 1'b1;

        go("R1 idle after reset");
        // R2 level sticky
        d_ev = 6'b000001; go("R2 R9 level sets");
        d_ev = 6'b000000; go("R2 R13 stays after input drops");
        clear_all("R12 write clears");
        // R3 rising only
        d_ev = 6'b001000; go("R3 rise sets");
        go("R3 held level");
        clear_all("R12 clear with level high");
        go("R3 steady level does not set");
        d_ev = 6'b000000; go("R3 fall does not set");
        // R4 falling only
        d_ev = 6'b000100; go("R4 rise does not set");
        d_ev = 6'b000000; go("R4 fall sets");
        clear_all("R12 clear");
        // R5 both edges
        d_ev = 6'b000010; go("R5 rise sets");
        clear_all("R5 clear with level high");
        go("R5 steady level does not set");
        d_ev = 6'b000000; go("R5 fall sets");
        clear_all("R12 clear");
        // R6 plain bit
        d_ev = 6'b010000; d_pen = 0; d_pnx = 1; go("R6 no load without enable");
        d_pen = 1; go("R6 load, no interrupt");
        d_pen = 0; d_pnx = 0; go("R6 holds");
        d_pen = 1; go("R6 loads zero");
        d_pen = 0; d_ev = 0;
        // R7 follow
        d_ev = 6'b100000; go("R7 follows high");
        d_ev = 6'b000000; go("R7 drops");
        // R8 masking
        d_m = 2'b11; d_ev = 6'b000011; go("R8 masked bits record");
        d_ev = 6'b000000; go("R8 masked still quiet");
        d_m = 2'b01; go("R8 R9 unmask bit 1");
        d_m = 2'b00;
        clear_all("R12 clear");
        // R12 write vs hardware
        d_ev = 6'b000001; d_ws = 1; d_wd = 0; go("R12 write beats level event");
        d_ws = 0; go("R2 sets after write");
        d_ev = 0; d_ws = 1; d_wd = 6'b111111; go("R12 write ones");
        d_ws = 0;
        clear_all("R12 clear");
        // Halt register
        d_hev = 5'b00001; go("R10 R11 halt level sets");
        d_hev = 5'b00000; go("R10 halt sticky");
        d_hm = 2'b01; go("R11 halt masked");
        d_hev = 5'b01000; go("R10 R11 plain halt bit follows, no halt");
        d_hev = 5'b00000; go("R10 plain halt bit drops");
        d_hm = 2'b11; d_hev = 5'b10110; go("R11 unmasked halt bits");
        d_hev = 0; d_wh = 1; d_wd = 0; go("R12 halt write clears");
        d_wh = 0; d_hm = 0; go("R13 idle end");

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R13: pending=%0d expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule